// File: doc/BRIEF.md
# Accumulator and Carry-Bit Unit

This unit is the arithmetic datapath of a small accumulator machine. It holds a 16-bit accumulator and a single carry/extend bit. Every instruction that changes either of them arrives as a one-cycle enable strobe from an external controller. The memory-side operations add, AND or load a 16-bit operand word into the accumulator. The register-side operations clear, complement, increment or rotate the accumulator, or clear or complement the extend bit.

The extend bit is a register of its own. An add writes its carry-out into it. In both rotate directions it acts as a 17th bit, so a rotate moves it into the accumulator and moves the bit that leaves the accumulator into it. Three combinational flags let the controller make skip decisions without another cycle: accumulator zero, accumulator sign and extend zero.

The controller raises at most one strobe per clock. When no strobe is raised, both registers keep their contents.

Top module: `acu_top`

## Requirements
- R1: While `rst_n` is low, the accumulator and the extend bit are asynchronously cleared to 0.
- R2: When `op_add` is high, the next state {ext, acc} is the 17-bit sum of acc and `mem_word`. Bit 16 of the sum goes to ext and bits 15:0 go to acc.
- R3: When `op_and` is high, acc becomes acc AND `mem_word`, and ext is unchanged.
- R4: When `op_load` is high, acc becomes `mem_word`, and ext is unchanged.
- R5: When `op_clr_acc` is high, acc becomes 0. When `op_inv_acc` is high, acc becomes its bitwise complement. In both cases ext is unchanged.
- R6: When `op_inc` is high, acc becomes acc+1 modulo 2^16, so 0xFFFF wraps to 0x0000, and ext is unchanged.
- R7: When `op_ror` is high, acc becomes {ext, acc[15:1]} and ext becomes the old acc[0].
- R8: When `op_rol` is high, acc becomes {acc[14:0], ext} and ext becomes the old acc[15].
- R9: When `op_clr_ext` is high, ext becomes 0. When `op_inv_ext` is high, ext is inverted. In both cases acc is unchanged.
- R10: At most one strobe is high in any cycle. In a cycle with no strobe high, acc and ext hold their values.
- R11: The flags follow the registered state in the same cycle: `acc_zero` is 1 exactly when acc is 0, `acc_neg` equals acc[15], and `ext_zero` is 1 exactly when ext is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_word | input | 16 | Operand word for add, AND and load |
| op_add | input | 1 | Add the operand into acc, carry-out into ext |
| op_and | input | 1 | AND the operand into acc |
| op_load | input | 1 | Load the operand into acc |
| op_clr_acc | input | 1 | Clear acc |
| op_inv_acc | input | 1 | Complement acc |
| op_inc | input | 1 | Increment acc |
| op_ror | input | 1 | Rotate {ext, acc} right |
| op_rol | input | 1 | Rotate {ext, acc} left |
| op_clr_ext | input | 1 | Clear ext |
| op_inv_ext | input | 1 | Complement ext |
| acc | output | 16 | Accumulator |
| ext | output | 1 | Extend/carry bit |
| acc_zero | output | 1 | acc equals zero |
| acc_neg | output | 1 | acc bit 15 |
| ext_zero | output | 1 | ext equals zero |

## Verification
One vector sequence chains every operation, so each expected state depends on the one before it. The adds are chosen to separate a carry of 1 from a carry of 0, which shows that an add overwrites ext rather than ORing into it. The rotates run with ext at 1 and with acc[0] or acc[15] set, so that a rotate missing the extend bit, or turning the wrong way, gives a different word. Increment is applied at 0xFFFF to expose a wrap that disturbs ext, and idle cycles with a changing operand show the hold case. A mid-run reset and a zero-valued accumulator exercise the flag outputs.

// File: rtl/acu_pkg.sv
package acu_pkg;

    typedef enum logic [3:0] {
        OP_HOLD,
        OP_ADD,
        OP_AND,
        OP_LOAD,
        OP_CLR_ACC,
        OP_INV_ACC,
        OP_INC,
        OP_ROR,
        OP_ROL,
        OP_CLR_EXT,
        OP_INV_EXT
    } acu_op_e;

    localparam int NUM_STROBES = 10;

endpackage

// File: rtl/acu_adder.sv
module acu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry
);
    always_comb begin
        {carry, sum} = {1'b0, a} + {1'b0, b};
    end
endmodule

// File: rtl/acu_rotator.sv
module acu_rotator #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_in,
    input  logic         ext_in,
    output logic [W-1:0] ror_acc,
    output logic         ror_ext,
    output logic [W-1:0] rol_acc,
    output logic         rol_ext
);
    // Each accumulator bit takes its neighbour; the extend bit closes the ring.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W-1) begin : g_top
            assign ror_acc[i] = ext_in;
        end else begin : g_mid_r
            assign ror_acc[i] = acc_in[i+1];
        end
        if (i == 0) begin : g_bot
            assign rol_acc[i] = ext_in;
        end else begin : g_mid_l
            assign rol_acc[i] = acc_in[i-1];
        end
    end
    assign ror_ext = acc_in[0];
    assign rol_ext = acc_in[W-1];
endmodule

// File: rtl/acu_flags.sv
module acu_flags #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_in,
    input  logic         ext_in,
    output logic         acc_zero,
    output logic         acc_neg,
    output logic         ext_zero
);
    assign acc_zero = (acc_in == '0);
    assign acc_neg  = acc_in[W-1];
    assign ext_zero = ~ext_in;
endmodule

// File: rtl/acu_top.sv
module acu_top #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mem_word,
    input  logic         op_add,
    input  logic         op_and,
    input  logic         op_load,
    input  logic         op_clr_acc,
    input  logic         op_inv_acc,
    input  logic         op_inc,
    input  logic         op_ror,
    input  logic         op_rol,
    input  logic         op_clr_ext,
    input  logic         op_inv_ext,
    output logic [W-1:0] acc,
    output logic         ext,
    output logic         acc_zero,
    output logic         acc_neg,
    output logic         ext_zero
);
    import acu_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] acc;
        logic         ext;
    } state_t;

    state_t  state_d, state_q;
    acu_op_e op_sel;

    logic [NUM_STROBES-1:0] strobes;
    assign strobes = {op_add, op_and, op_load, op_clr_acc, op_inv_acc,
                      op_inc, op_ror, op_rol, op_clr_ext, op_inv_ext};

    logic [W-1:0] sum_w;
    logic         sum_c;
    logic [W-1:0] ror_acc_w, rol_acc_w;
    logic         ror_ext_w, rol_ext_w;

    acu_adder #(.W(W)) u_adder (
        .a     (state_q.acc),
        .b     (mem_word),
        .sum   (sum_w),
        .carry (sum_c)
    );

    acu_rotator #(.W(W)) u_rot (
        .acc_in  (state_q.acc),
        .ext_in  (state_q.ext),
        .ror_acc (ror_acc_w),
        .ror_ext (ror_ext_w),
        .rol_acc (rol_acc_w),
        .rol_ext (rol_ext_w)
    );

    acu_flags #(.W(W)) u_flags (
        .acc_in   (state_q.acc),
        .ext_in   (state_q.ext),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ext_zero (ext_zero)
    );

    always_comb begin
        if      (op_add)     op_sel = OP_ADD;
        else if (op_and)     op_sel = OP_AND;
        else if (op_load)    op_sel = OP_LOAD;
        else if (op_clr_acc) op_sel = OP_CLR_ACC;
        else if (op_inv_acc) op_sel = OP_INV_ACC;
        else if (op_inc)     op_sel = OP_INC;
        else if (op_ror)     op_sel = OP_ROR;
        else if (op_rol)     op_sel = OP_ROL;
        else if (op_clr_ext) op_sel = OP_CLR_EXT;
        else if (op_inv_ext) op_sel = OP_INV_EXT;
        else                 op_sel = OP_HOLD;
    end

    always_comb begin
        state_d = state_q;
        case (op_sel)
            OP_ADD:     begin state_d.acc = sum_w;     state_d.ext = sum_c;     end
            OP_AND:     state_d.acc = state_q.acc & mem_word;
            OP_LOAD:    state_d.acc = mem_word;
            OP_CLR_ACC: state_d.acc = '0;
            OP_INV_ACC: state_d.acc = ~state_q.acc;
            OP_INC:     state_d.acc = state_q.acc + ONE;
            OP_ROR:     begin state_d.acc = ror_acc_w; state_d.ext = ror_ext_w; end
            OP_ROL:     begin state_d.acc = rol_acc_w; state_d.ext = rol_ext_w; end
            OP_CLR_EXT: state_d.ext = 1'b0;
            OP_INV_EXT: state_d.ext = ~state_q.ext;
            default:    state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign acc = state_q.acc;
    assign ext = state_q.ext;

    // R10: the controller raises no more than one strobe per cycle
    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    // R10: idle cycles keep both registers
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (strobes == '0) |=> ($stable(acc) && $stable(ext)));

    // R2: the 17-bit sum lands in {ext, acc}
    a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        op_add |=> ({ext, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mem_word)})));

    // R6: increment wraps and leaves ext alone
    a_r6_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        op_inc |=> ((acc == $past(acc) + ONE) && $stable(ext)));

    // R7: right rotation through ext
    a_r7_ror: assert property (@(posedge clk) disable iff (!rst_n)
        op_ror |=> ((acc == {$past(ext), $past(acc[W-1:1])}) && (ext == $past(acc[0]))));

    // R8: left rotation through ext
    a_r8_rol: assert property (@(posedge clk) disable iff (!rst_n)
        op_rol |=> ((acc == {$past(acc[W-2:0]), $past(ext)}) && (ext == $past(acc[W-1]))));

    // R9: ext-only operations leave acc alone
    a_r9_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (op_clr_ext || op_inv_ext) |=> $stable(acc));

    // R11: flags agree with the registered state
    a_r11_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_neg == acc[W-1]) && (ext_zero != ext) && (acc_zero == (acc == '0)));

endmodule

// File: tb/acu_top_test.sv
module acu_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_word = '0;
    logic [9:0]  strobe = '0;
    logic [15:0] acc;
    logic        ext, acc_zero, acc_neg, ext_zero;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    acu_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_word   (mem_word),
        .op_add     (strobe[0]),
        .op_and     (strobe[1]),
        .op_load    (strobe[2]),
        .op_clr_acc (strobe[3]),
        .op_inv_acc (strobe[4]),
        .op_inc     (strobe[5]),
        .op_ror     (strobe[6]),
        .op_rol     (strobe[7]),
        .op_clr_ext (strobe[8]),
        .op_inv_ext (strobe[9]),
        .acc        (acc),
        .ext        (ext),
        .acc_zero   (acc_zero),
        .acc_neg    (acc_neg),
        .ext_zero   (ext_zero)
    );

    // op codes: 0 idle, 1 add, 2 and, 3 load, 4 clr acc, 5 inv acc,
    // 6 inc, 7 ror, 8 rol, 9 clr ext, 10 inv ext
    // entry = {op[3:0], operand[15:0], expected acc[15:0], expected ext}
    localparam int NV = 19;
    localparam logic [36:0] VEC [NV] = '{
        {4'd3,  16'h0F0F, 16'h0F0F, 1'b0},  // R4 load
        {4'd1,  16'hF102, 16'h0011, 1'b1},  // R2 add with carry out
        {4'd0,  16'h1234, 16'h0011, 1'b1},  // R10 idle
        {4'd7,  16'h0000, 16'h8008, 1'b1},  // R7 ror
        {4'd8,  16'h0000, 16'h0011, 1'b1},  // R8 rol
        {4'd9,  16'h0000, 16'h0011, 1'b0},  // R9 clr ext
        {4'd10, 16'h0000, 16'h0011, 1'b1},  // R9 inv ext
        {4'd2,  16'h00F0, 16'h0010, 1'b1},  // R3 and
        {4'd5,  16'h0000, 16'hFFEF, 1'b1},  // R5 inv acc
        {4'd6,  16'h0000, 16'hFFF0, 1'b1},  // R6 inc
        {4'd3,  16'hFFFF, 16'hFFFF, 1'b1},  // R4 load
        {4'd6,  16'h0000, 16'h0000, 1'b1},  // R6 wrap
        {4'd5,  16'h0000, 16'hFFFF, 1'b1},  // R5 inv acc
        {4'd8,  16'h0000, 16'hFFFF, 1'b1},  // R8 rol all ones
        {4'd4,  16'h0000, 16'h0000, 1'b1},  // R5 clr acc
        {4'd7,  16'h0000, 16'h8000, 1'b0},  // R7 ror ext into msb
        {4'd1,  16'h8000, 16'h0000, 1'b1},  // R2 add overflow to zero
        {4'd1,  16'h0001, 16'h0001, 1'b0},  // R2 add clears ext
        {4'd0,  16'hFFFF, 16'h0001, 1'b0}   // R10 idle
    };

    task automatic check(input string req, input logic [15:0] exp_acc, input logic exp_ext);
        n_checks++;
        if (acc !== exp_acc || ext !== exp_ext) begin
            n_fail++;
            $display("FAIL %s state: acc=%h ext=%b expected acc=%h ext=%b",
                     req, acc, ext, exp_acc, exp_ext);
        end
        n_checks++;
        if (acc_zero !== (exp_acc == 16'h0) || acc_neg !== exp_acc[15] || ext_zero !== !exp_ext) begin
            n_fail++;
            $display("FAIL R11 flags after %s: z=%b n=%b ez=%b expected z=%b n=%b ez=%b",
                     req, acc_zero, acc_neg, ext_zero, exp_acc == 16'h0, exp_acc[15], !exp_ext);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] word);
        @(negedge clk);
        mem_word = word;
        strobe   = (op == 4'd0) ? 10'd0 : (10'd1 << (op - 4'd1));
        @(posedge clk);
        #1;
        strobe = '0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1;
        check("R1 reset held", 16'h0000, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][36:33], VEC[i][32:17]);
            check($sformatf("R2-R10 vector %0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // R1: asynchronous clear mid-run, between clock edges
        apply(4'd3, 16'hA5A5);
        check("R4 load before reset", 16'hA5A5, 1'b0);
        apply(4'd10, 16'h0000);
        check("R9 inv ext before reset", 16'hA5A5, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        check("R1 async clear", 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: increment from zero with ext at 1 keeps ext
        apply(4'd10, 16'h0000);
        apply(4'd6, 16'h0000);
        check("R6 inc from zero", 16'h0001, 1'b1);
        // R3: AND with zero operand gives zero flag
        apply(4'd2, 16'h0000);
        check("R3 and zero", 16'h0000, 1'b1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            finish_run();
        end
    end

endmodule